// File: doc/BRIEF.md
# SDRAM Mode-Register Burst Sequencer

This block models the command-side sequencing of a single-data-rate synchronous DRAM device. A LOAD MODE command captures a mode word. The block decodes five settings from that word: burst length, column ordering, CAS latency, the operating-mode field and a write-burst override. Each READ or WRITE command then produces a stream of column addresses, one per clock. For reads, the block also produces a data-valid strobe and an output-enable strobe. Both are delayed by the programmed CAS latency.

The column stream cannot be stalled. It has no ready input, so there is no back-pressure: one column leaves per cycle while `col_valid` is high. A mode word that carries a reserved code is refused. So is a CAS latency that the clock frequency set by parameter does not allow. A refused word raises a one-cycle error pulse, and the earlier settings stay in force. The control pins (`cmd`, `mode_word`, `mode_error`) are plain, level-sampled signals.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, all outputs are low and the settings are burst length 1, sequential order, CAS latency 3, normal mode and write bursts enabled.
- R2: `cmd` encodes 0 = NOP, 1 = LOAD MODE, 2 = READ, 3 = WRITE. A READ or WRITE sampled at edge n drives `col_valid` high from edge n for as many consecutive cycles as the burst length. The first column equals `start_col`, and `col_write` is high for WRITE beats.
- R3: `mode_word[2:0]` selects the burst length: 000 = 1, 001 = 2, 010 = 4, 011 = 8. Codes 100 to 111 are reserved.
- R4: When `mode_word[3]` = 0 (sequential), beat k of a burst of length L addresses the aligned block of L columns that holds the start column, at offset (start mod L + k) mod L.
- R5: When `mode_word[3]` = 1 (interleaved), beat k addresses the same aligned block at offset (start mod L) XOR k.
- R6: `mode_word[6:4]` sets the CAS latency m, with code 2 for two clocks and code 3 for three. Every other code is reserved. The read beat issued at edge n+k raises `rd_valid` at edge n+k+m.
- R7: `rd_oe` is high from one edge before each `rd_valid` pulse and stays high through every cycle in which `rd_valid` is high.
- R8: `mode_word[8:7]` must be 00 (normal operation). Any other value is refused.
- R9: When `mode_word[9]` = 1, every WRITE produces exactly one beat and reads keep the programmed length. When the bit is 0, both commands use the programmed length.
- R10: A LOAD MODE word with a reserved or refused field pulses `mode_error` high for exactly one cycle and leaves every setting unchanged.
- R11: CAS latency 2 is refused when parameter `CLK_MHZ` exceeds `MAX_MHZ_CL2`. CAS latency 3 is refused when `CLK_MHZ` exceeds `MAX_MHZ_CL3`.
- R12: A READ or WRITE arriving during a burst ends that burst and starts the new sequence at the same edge. Read beats already issued still appear on `rd_valid` at their latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Decoded command |
| mode_word | input | MODE_W | Mode word, sampled on LOAD MODE |
| start_col | input | COL_W | Start column, sampled on READ or WRITE |
| burst_col | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | `burst_col` holds a beat this cycle |
| col_write | output | 1 | Current beat belongs to a WRITE |
| rd_valid | output | 1 | Read data slot valid (CAS-delayed) |
| rd_oe | output | 1 | Output drivers enabled |
| mode_error | output | 1 | One-cycle pulse for a refused mode word |

## Verification
The in-line properties hold on every cycle. They cover the following:
- `rd_oe` leads each rising `rd_valid` and covers it.
- Each `rd_valid` pulse comes from a read beat exactly two or three cycles earlier.
- A continuing beat never leaves its aligned column block.
- A single-write setting never produces a second write beat.
- A refused mode word never changes the stored settings.

The exact column orderings, the reset defaults, the reserved-code decoding and the frequency limit can only be shown by the bench's scenarios. The same holds for truncation, where a new command keeps the read slots already issued. The bench compares each cycle against its own model of these rules.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_e;

  localparam int MAX_BLEN = 8;
  localparam int LEN_W    = $clog2(MAX_BLEN) + 1;
  localparam int CL_W     = 2;
  localparam int MAX_CL   = 3;

  typedef struct packed {
    logic [LEN_W-1:0] blen;
    logic             ilv;
    logic [CL_W-1:0]  cl;
    logic             wr_single;
  } mode_cfg_t;

  localparam mode_cfg_t CFG_DEFAULT = '{blen: LEN_W'(1), ilv: 1'b0,
                                        cl: CL_W'(3), wr_single: 1'b0};

endpackage

// File: rtl/sdram_mode_reg.sv
`timescale 1ns/1ps
module sdram_mode_reg
  import sdram_seq_pkg::*;
#(
  parameter int MODE_W      = 12,
  parameter int CLK_MHZ     = 100,
  parameter int MAX_MHZ_CL2 = 100,
  parameter int MAX_MHZ_CL3 = 133
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] mode_word,
  output mode_cfg_t         cfg,
  output logic              mode_error
);

  localparam bit CL2_OK = (CLK_MHZ <= MAX_MHZ_CL2);
  localparam bit CL3_OK = (CLK_MHZ <= MAX_MHZ_CL3);

  logic [2:0]       bl_code;
  logic [2:0]       cl_code;
  logic [1:0]       op_code;
  logic [LEN_W-1:0] dec_len;
  logic             bl_ok, cl_ok, op_ok;
  mode_cfg_t        next_cfg;

  always_comb begin
    bl_code = mode_word[2:0];
    cl_code = mode_word[6:4];
    op_code = mode_word[8:7];
    bl_ok   = 1'b1;
    case (bl_code)
      3'b000:  dec_len = LEN_W'(1);
      3'b001:  dec_len = LEN_W'(2);
      3'b010:  dec_len = LEN_W'(4);
      3'b011:  dec_len = LEN_W'(8);
      default: begin dec_len = LEN_W'(1); bl_ok = 1'b0; end
    endcase
    cl_ok = ((cl_code == 3'd2) && CL2_OK) || ((cl_code == 3'd3) && CL3_OK);
    op_ok = (op_code == 2'b00);
    next_cfg.blen      = dec_len;
    next_cfg.ilv       = mode_word[3];
    next_cfg.cl        = cl_code[CL_W-1:0];
    next_cfg.wr_single = mode_word[9];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg        <= CFG_DEFAULT;
      mode_error <= 1'b0;
    end else begin
      mode_error <= 1'b0;
      if (load) begin
        if (bl_ok && cl_ok && op_ok) cfg <= next_cfg;
        else                         mode_error <= 1'b1;
      end
    end
  end

  // R10: a refused word leaves settings untouched
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_error |-> (cfg == $past(cfg)));

  // R10: error pulse only follows a load
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_error |-> $past(load));

endmodule

// File: rtl/sdram_burst_gen.sv
`timescale 1ns/1ps
module sdram_burst_gen
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_write,
  input  logic [LEN_W-1:0] go_len,
  input  logic             go_ilv,
  input  logic [COL_W-1:0] go_col,
  output logic [COL_W-1:0] burst_col,
  output logic             col_valid,
  output logic             col_write
);

  logic             act_q, wr_q, ilv_q;
  logic [LEN_W-1:0] len_q, k_q;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] mask, k_ext, lo;

  always_comb begin
    mask  = {{(COL_W-LEN_W){1'b0}}, len_q} - COL_W'(1);
    k_ext = {{(COL_W-LEN_W){1'b0}}, k_q};
    lo    = ilv_q ? (start_q ^ k_ext) : (start_q + k_ext);
    burst_col = (start_q & ~mask) | (lo & mask);
  end

  assign col_valid = act_q;
  assign col_write = wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      ilv_q   <= 1'b0;
      len_q   <= LEN_W'(1);
      k_q     <= '0;
      start_q <= '0;
    end else if (go) begin
      act_q   <= 1'b1;
      wr_q    <= go_write;
      ilv_q   <= go_ilv;
      len_q   <= go_len;
      k_q     <= '0;
      start_q <= go_col;
    end else if (act_q) begin
      if (k_q == len_q - LEN_W'(1)) begin
        act_q <= 1'b0;
        wr_q  <= 1'b0;
      end else begin
        k_q <= k_q + LEN_W'(1);
      end
    end
  end

  // R4, R5: a continuing beat stays inside the aligned block
  p_same_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(col_valid) && !$past(go))
      |-> (((burst_col ^ $past(burst_col)) & ~mask) == '0));

endmodule

// File: rtl/sdram_cas_pipe.sv
`timescale 1ns/1ps
module sdram_cas_pipe
  import sdram_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat,
  input  logic [CL_W-1:0] cl,
  output logic            rd_valid,
  output logic            rd_oe
);

  logic [MAX_CL-1:0] sh;
  logic              lead;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[MAX_CL-2:0], beat};
  end

  always_comb begin
    rd_valid = 1'b0;
    lead     = 1'b0;
    for (int i = 0; i < MAX_CL; i++) begin
      if (i + 1 == int'(cl)) rd_valid = sh[i];
      if (i + 2 == int'(cl)) lead     = sh[i];
    end
    rd_oe = lead | rd_valid;
  end

  // R7: drivers on one cycle before the first data slot
  p_oe_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(rd_oe));

  // R6: each data slot comes from a beat exactly m cycles back
  p_cl2_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cl == 2'd2 && $past(cl) == 2'd2) |-> $past(beat, 2));

  p_cl3_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cl == 2'd3 && $past(cl) == 2'd3) |-> $past(beat, 3));

endmodule

// File: rtl/sdram_burst_seq.sv
`timescale 1ns/1ps
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int COL_W       = 10,
  parameter int MODE_W      = 12,
  parameter int CLK_MHZ     = 100,
  parameter int MAX_MHZ_CL2 = 100,
  parameter int MAX_MHZ_CL3 = 133
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [MODE_W-1:0] mode_word,
  input  logic [COL_W-1:0]  start_col,
  output logic [COL_W-1:0]  burst_col,
  output logic              col_valid,
  output logic              col_write,
  output logic              rd_valid,
  output logic              rd_oe,
  output logic              mode_error
);

  cmd_e             c;
  mode_cfg_t        cfg;
  logic             go, go_write, load;
  logic [LEN_W-1:0] go_len;

  always_comb begin
    c        = cmd_e'(cmd);
    load     = (c == CMD_LOAD);
    go       = (c == CMD_READ) || (c == CMD_WRITE);
    go_write = (c == CMD_WRITE);
    go_len   = (go_write && cfg.wr_single) ? LEN_W'(1) : cfg.blen;
  end

  sdram_mode_reg #(
    .MODE_W(MODE_W), .CLK_MHZ(CLK_MHZ),
    .MAX_MHZ_CL2(MAX_MHZ_CL2), .MAX_MHZ_CL3(MAX_MHZ_CL3)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .load(load), .mode_word(mode_word),
    .cfg(cfg), .mode_error(mode_error)
  );

  sdram_burst_gen #(.COL_W(COL_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .go(go), .go_write(go_write),
    .go_len(go_len), .go_ilv(cfg.ilv), .go_col(start_col),
    .burst_col(burst_col), .col_valid(col_valid), .col_write(col_write)
  );

  sdram_cas_pipe u_cas (
    .clk(clk), .rst_n(rst_n), .beat(col_valid & ~col_write), .cl(cfg.cl),
    .rd_valid(rd_valid), .rd_oe(rd_oe)
  );

  // R9: with single writes set, no write beat continues a burst
  p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_write && cfg.wr_single && $stable(cfg)) |-> $past(go));

endmodule

// File: tb/sdram_burst_seq_test.sv
`timescale 1ns/1ps
module sdram_burst_seq_test;

  localparam int N = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [11:0] mode_word = '0;
  logic [9:0]  start_col = '0;
  logic [9:0]  burst_col, f_col;
  logic        col_valid, col_write, rd_valid, rd_oe, mode_error;
  logic        f_v, f_w, f_rv, f_oe, f_err;

  always #4 clk = ~clk;

  sdram_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .mode_word(mode_word),
    .start_col(start_col), .burst_col(burst_col), .col_valid(col_valid),
    .col_write(col_write), .rd_valid(rd_valid), .rd_oe(rd_oe),
    .mode_error(mode_error));

  // R11: same block at a clock too fast for latency 2
  sdram_burst_seq #(.CLK_MHZ(125)) uut_fast (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .mode_word(mode_word),
    .start_col(start_col), .burst_col(f_col), .col_valid(f_v),
    .col_write(f_w), .rd_valid(f_rv), .rd_oe(f_oe), .mode_error(f_err));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  int m_blen = 1, m_cl = 3;
  bit m_ilv = 0, m_wrs = 0;
  bit e_v[N];
  bit e_w[N];
  int e_c[N];

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [11:0] mw(int bl, bit ilv, int cl, int op, bit wrs);
    return {2'b00, wrs, 2'(op), 3'(cl), ilv, 3'(bl)};
  endfunction

  function automatic int ref_col(int s, int k, int len, bit ilv);
    int base = s - (s % len);
    int off  = ilv ? ((s % len) ^ k) : (((s % len) + k) % len);
    return base + off;
  endfunction

  task automatic step(logic [1:0] c, logic [11:0] w, logic [9:0] sc);
    int len, t, ebl, ecl;
    bit ok, eerr, ferr, erd, eoe;
    @(negedge clk);
    cmd = c; mode_word = w; start_col = sc;
    @(posedge clk);
    cyc++;
    eerr = 0; ferr = 0;
    if (c == 2'd1) begin
      ecl = int'(w[6:4]);
      ok = (w[2:0] < 3'd4) && (ecl == 2 || ecl == 3) && (w[8:7] == 2'b00);
      if (!ok) begin eerr = 1; ferr = 1; end
      else begin
        ferr = (ecl == 2);
        ebl = 1 << int'(w[2:0]);
        m_blen = ebl; m_ilv = w[3]; m_cl = ecl; m_wrs = w[9];
      end
    end
    if (c[1]) begin
      len = (c == 2'd3 && m_wrs) ? 1 : m_blen;
      for (int i = cyc; i < cyc + 9; i++) e_v[i] = 0;
      for (int k = 0; k < len; k++) begin
        e_v[cyc+k] = 1; e_w[cyc+k] = (c == 2'd3);
        e_c[cyc+k] = ref_col(int'(sc), k, len, m_ilv);
      end
    end
    #1;
    chk("R2 col_valid", int'(col_valid), int'(e_v[cyc]));
    if (e_v[cyc]) begin
      chk("R4/R5 burst_col", int'(burst_col), e_c[cyc]);
      chk("R9 col_write", int'(col_write), int'(e_w[cyc]));
    end
    t = cyc - m_cl;
    erd = (t >= 0) && e_v[t] && !e_w[t];
    t = cyc + 1 - m_cl;
    eoe = erd || ((t >= 0) && e_v[t] && !e_w[t]);
    chk("R6 rd_valid", int'(rd_valid), int'(erd));
    chk("R7 rd_oe", int'(rd_oe), int'(eoe));
    chk("R10 mode_error", int'(mode_error), int'(eerr));
    chk("R11 fast mode_error", int'(f_err), int'(ferr));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(2'd0, '0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    int r;
    void'($urandom(32'd20250));
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state of the outputs
    chk("R1 col_valid", int'(col_valid), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 rd_oe", int'(rd_oe), 0);
    chk("R1 mode_error", int'(mode_error), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: default length 1, latency 3
    step(2'd2, '0, 10'd5); idle(5);
    step(2'd3, '0, 10'd9); idle(3);
    // R3, R4: length 8 sequential wrap, latency 2
    step(2'd1, mw(3, 0, 2, 0, 0), '0); idle(2);
    step(2'd2, '0, 10'd13); idle(12);
    // R5: interleaved length 4 from column 6
    step(2'd1, mw(2, 1, 3, 0, 0), '0); idle(2);
    step(2'd2, '0, 10'd6); idle(8);
    // R9: single-location writes, reads still burst
    step(2'd1, mw(1, 0, 3, 0, 1), '0); idle(2);
    step(2'd3, '0, 10'd3); idle(3);
    step(2'd2, '0, 10'd3); idle(6);
    // R12: truncation by a new read and then a write
    step(2'd1, mw(3, 0, 3, 0, 0), '0); idle(2);
    step(2'd2, '0, 10'd40); idle(1);
    step(2'd2, '0, 10'd100); idle(2);
    step(2'd3, '0, 10'd7); idle(14);
    // R3, R6, R8, R10: reserved codes refused
    step(2'd1, mw(4, 0, 3, 0, 0), '0); idle(1);
    step(2'd1, mw(0, 0, 1, 0, 0), '0); idle(1);
    step(2'd1, mw(0, 0, 3, 1, 0), '0); idle(1);
    step(2'd1, mw(0, 0, 3, 2, 0), '0); idle(1);
    step(2'd2, '0, 10'd21); idle(12);
    // random phase
    for (int n = 0; n < 600; n++) begin
      r = int'($urandom_range(0, 99));
      if (r < 8) begin
        idle(12);
        step(2'd1, mw(int'($urandom_range(0, 7)) % (r < 2 ? 8 : 4),
                      1'($urandom_range(0, 1)),
                      (r == 3) ? int'($urandom_range(0, 7)) : int'($urandom_range(2, 3)),
                      (r == 4) ? int'($urandom_range(0, 3)) : 0,
                      1'($urandom_range(0, 1))), '0);
      end else if (r < 45) step(2'd0, '0, '0);
      else if (r < 75) step(2'd2, '0, 10'($urandom));
      else step(2'd3, '0, 10'($urandom));
    end
    idle(12);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
    end
  end

endmodule